// File: doc/BRIEF.md
# Slotted Switch Traffic Source and Throughput Meter

This block drives the inputs of a slotted N-port cell switch and measures what the switch delivers. Every clock cycle is one slot. Each input owns one head-cell register. In random-arrival mode, the head register is refilled in a slot with a programmable probability. Each input decides on its own, from its own pseudo-random stream. Every cell carries a destination drawn with equal odds over the N outputs. In saturated mode, the inputs behave as if their queues were never empty: whenever a head cell is taken, a fresh one stands in its place in the next slot.

The switch under test accepts a head cell by raising that input's ready line. It reports each output that delivered a cell in a slot on a per-output delivered line. A start pulse clears the 32-bit slot counter and the per-output delivery counters and sets them running. A stop pulse freezes them for readout. An output's throughput is its delivery count divided by the slot count, which is one minus the fraction of idle slots at that output.

Top module: `slot_traffic_gen`

## Requirements
- R1: Out of reset no cell is offered (`cell_valid_o` all zero), `meter_on_o` is low, and the slot and delivery counters read zero.
- R2: In random-arrival mode with `prob_i` = 0, an input with no head cell stays empty for as long as the setting holds.
- R3: In random-arrival mode, a free input takes a new cell in a slot when 16 fresh bits of its stream are below `prob_i`. The per-input offer rate therefore tracks `prob_i`/65536 (0x4000 gives about 25% with ready held high).
- R4: Every offered destination is below N and the N outputs are equally likely. When N is not a power of two, out-of-range draws are rejected, and up to two draws are tried per slot.
- R5: While an input offers a cell that is not accepted, `cell_valid_o` for that input stays high and its destination field does not change. An arrival in such a slot is lost.
- R6: In saturated mode with N a power of two, an input that holds a cell in a slot holds one in the next slot. A departure is replaced by a new cell at once.
- R7: A start pulse sets `meter_on_o` and clears all counters. The first slot counted is the one after the pulse. A start pulse takes priority over a stop pulse in the same slot.
- R8: While running, the slot counter adds one per slot. Delivery counter j (bits 32j and up of `dlv_cnt_o`) adds one in each slot where `dlv_valid_i[j]` is high.
- R9: A stop pulse clears `meter_on_o`. The slot of the pulse and all later slots are not counted, and every counter holds its value until the next start.
- R10: Each input's stream is seeded differently, so the arrival patterns of two inputs differ.
- R11: With N = 2 in saturated mode and a switch that grants each output to one of its contending head cells at random, the measured throughput of each output is close to 75%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prob_i | input | PROB_W | Arrival probability as a fraction of 2^PROB_W |
| saturate_i | input | 1 | 1: inputs permanently backlogged; 0: random arrivals |
| start_i | input | 1 | Clear counters and start measuring |
| stop_i | input | 1 | Freeze counters |
| cell_valid_o | output | N_PORTS | Head cell present, per input |
| cell_dest_o | output | N_PORTS*DW | Destination of each head cell, DW bits per input, input 0 lowest |
| cell_ready_i | input | N_PORTS | Switch takes the head cell of that input this slot |
| dlv_valid_i | input | N_PORTS | Output delivered a cell this slot |
| meter_on_o | output | 1 | Counters are running |
| slot_cnt_o | output | CNT_W | Slots counted since start |
| dlv_cnt_o | output | N_PORTS*CNT_W | Delivered cells per output, output 0 lowest |

## Verification
Random arrivals are tried at zero load, at near-full load against a stalled switch, and at a quarter load against an always-ready switch. These patterns separate the idle case, the hold-under-backpressure case and the rate of the comparison against the stream. The quarter-load run also compares two inputs' patterns to expose shared seeds. A second instance with three outputs runs saturated, which shows whether rejection keeps destinations in range and evenly spread. Saturated mode with random ready lines shows whether every departure is refilled in the next slot. A two-port instance driven by a randomly arbitrating switch model ties the generator and the meter together against the expected 75% figure. Directed start, stop and start-with-stop pulses around random delivery patterns pin down which slots are counted.

// File: rtl/slot_traffic_gen.sv
module slot_traffic_gen #(
  parameter int N_PORTS = 4,
  parameter int PROB_W = 16,
  parameter int CNT_W = 32,
  parameter int LFSR_W = 32,
  parameter int TRIES = 2,
  parameter logic [LFSR_W-1:0] TAPS = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] SEED = 32'h5A17_C3E9,
  localparam int DW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PROB_W-1:0]          prob_i,
  input  logic                       saturate_i,
  input  logic                       start_i,
  input  logic                       stop_i,
  output logic [N_PORTS-1:0]         cell_valid_o,
  output logic [N_PORTS*DW-1:0]      cell_dest_o,
  input  logic [N_PORTS-1:0]         cell_ready_i,
  input  logic [N_PORTS-1:0]         dlv_valid_i,
  output logic                       meter_on_o,
  output logic [CNT_W-1:0]           slot_cnt_o,
  output logic [N_PORTS*CNT_W-1:0]   dlv_cnt_o
);

  localparam logic [DW:0] NPV = (DW+1)'(N_PORTS);
  localparam bit POW2 = ((1 << DW) == N_PORTS);

  function automatic logic [LFSR_W-1:0] rng_step(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] r;
    r = s;
    for (int k = 0; k < LFSR_W; k++)
      r = r[0] ? ((r >> 1) ^ TAPS) : (r >> 1);
    return r;
  endfunction

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    localparam logic [LFSR_W-1:0] SEED_I = (SEED << 16) | LFSR_W'(i + 1);
    logic [LFSR_W-1:0] rng_q;
    logic head_v, dst_ok, arrive, dep, load, pick_ok;
    logic [DW-1:0] head_d, dst_q, pick;

    always_comb begin
      pick = '0;
      pick_ok = 1'b0;
      for (int k = TRIES - 1; k >= 0; k--)
        if ({1'b0, rng_q[PROB_W + k*DW +: DW]} < NPV) begin
          pick = rng_q[PROB_W + k*DW +: DW];
          pick_ok = 1'b1;
        end
    end

    assign arrive = rng_q[PROB_W-1:0] < prob_i;
    assign dep    = head_v & cell_ready_i[i];
    assign load   = (~head_v | dep) & dst_ok & (saturate_i | arrive);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rng_q  <= SEED_I;
        head_v <= 1'b0;
        head_d <= '0;
        dst_q  <= '0;
        dst_ok <= 1'b0;
      end else begin
        rng_q <= rng_step(rng_q);
        if (load) begin
          head_v <= 1'b1;
          head_d <= dst_q;
        end else if (dep) begin
          head_v <= 1'b0;
        end
        if (!dst_ok || load) begin
          dst_q  <= pick;
          dst_ok <= pick_ok;
        end
      end
    end

    assign cell_valid_o[i] = head_v;
    assign cell_dest_o[i*DW +: DW] = head_d;

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_valid_o[i] && !cell_ready_i[i]) |=>
        (cell_valid_o[i] && $stable(cell_dest_o[i*DW +: DW])));

    p_dest_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cell_valid_o[i] |-> ({1'b0, cell_dest_o[i*DW +: DW]} < NPV));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!saturate_i && prob_i == '0 && !cell_valid_o[i]) |=> !cell_valid_o[i]);

    if (POW2) begin : g_sat
      p_backlog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (saturate_i && cell_valid_o[i]) |=> cell_valid_o[i]);
    end
  end

  logic run_q;
  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      slot_q <= '0;
    end else if (stop_i) begin
      run_q  <= 1'b0;
    end else if (run_q) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign meter_on_o = run_q;
  assign slot_cnt_o = slot_q;

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    logic [CNT_W-1:0] dcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dcnt_q <= '0;
      else if (start_i)
        dcnt_q <= '0;
      else if (run_q && !stop_i && dlv_valid_i[j])
        dcnt_q <= dcnt_q + 1'b1;
    end
    assign dlv_cnt_o[j*CNT_W +: CNT_W] = dcnt_q;

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!meter_on_o && !start_i) |=> $stable(dlv_cnt_o[j*CNT_W +: CNT_W]));
  end

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (meter_on_o && slot_cnt_o == '0));

  p_slot_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!meter_on_o && !start_i) |=> $stable(slot_cnt_o));

  p_slot_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (meter_on_o && !start_i && !stop_i) |=> (slot_cnt_o != '0));

endmodule

// File: tb/slot_traffic_gen_test.sv
module slot_traffic_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // main instance, N=4
  logic [15:0] prob;
  logic sat, start, stop;
  logic [3:0] ready, dlv, valid;
  logic [7:0] dest;
  logic meter_on;
  logic [31:0] slot;
  logic [127:0] dcnt;

  slot_traffic_gen #(.N_PORTS(4)) uut (
    .clk(clk), .rst_n(rst_n), .prob_i(prob), .saturate_i(sat),
    .start_i(start), .stop_i(stop), .cell_valid_o(valid), .cell_dest_o(dest),
    .cell_ready_i(ready), .dlv_valid_i(dlv), .meter_on_o(meter_on),
    .slot_cnt_o(slot), .dlv_cnt_o(dcnt));

  // three-port instance, saturated, always ready
  logic [2:0] valid3;
  logic [5:0] dest3;
  logic meter3;
  logic [31:0] slot3;
  logic [95:0] dcnt3;

  slot_traffic_gen #(.N_PORTS(3)) uut3 (
    .clk(clk), .rst_n(rst_n), .prob_i(16'h0), .saturate_i(1'b1),
    .start_i(1'b0), .stop_i(1'b0), .cell_valid_o(valid3), .cell_dest_o(dest3),
    .cell_ready_i(3'b111), .dlv_valid_i(3'b000), .meter_on_o(meter3),
    .slot_cnt_o(slot3), .dlv_cnt_o(dcnt3));

  // two-port instance, saturated, bench acts as a randomly arbitrating switch
  logic start2, stop2;
  logic [1:0] ready2, dlv2, valid2, dest2;
  logic meter2;
  logic [31:0] slot2;
  logic [63:0] dcnt2;

  slot_traffic_gen #(.N_PORTS(2)) uut2 (
    .clk(clk), .rst_n(rst_n), .prob_i(16'h0), .saturate_i(1'b1),
    .start_i(start2), .stop_i(stop2), .cell_valid_o(valid2), .cell_dest_o(dest2),
    .cell_ready_i(ready2), .dlv_valid_i(dlv2), .meter_on_o(meter2),
    .slot_cnt_o(slot2), .dlv_cnt_o(dcnt2));

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    int vcnt[4];
    int hist[4];
    int hist3[3];
    int diff01, total, total3, exp_slot;
    int exp_d[4];
    logic [7:0] held;
    void'($urandom(32'd1234));
    prob = 0; sat = 0; start = 0; stop = 0; ready = 0; dlv = 0;
    start2 = 0; stop2 = 0; ready2 = 0; dlv2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(valid == 4'h0, "R1 valid", valid, 0);
    chk(meter_on == 1'b0, "R1 meter_on", meter_on, 0);
    chk(slot == 0 && dcnt == '0, "R1 counters", slot, 0);

    // R5: near-full load, switch stalled
    prob = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk(valid == 4'hF, "R5 filled", valid, 15);
    held = dest;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(valid == 4'hF && dest == held, "R5 hold", dest, held);
    end

    // R2: zero load drains and stays empty
    prob = 16'h0; ready = 4'hF;
    @(negedge clk);
    chk(valid == 4'h0, "R2 drain", valid, 0);
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (valid != 4'h0) chk(1'b0, "R2 idle", valid, 0);
    end
    chk(valid == 4'h0, "R2 idle end", valid, 0);

    // R3, R4, R10: quarter load, always ready; uut3 saturated meanwhile
    prob = 16'h4000;
    foreach (vcnt[k]) begin vcnt[k] = 0; hist[k] = 0; end
    foreach (hist3[k]) hist3[k] = 0;
    diff01 = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        if (valid[i]) begin vcnt[i]++; hist[dest[i*2 +: 2]]++; end
      if (valid[0] != valid[1]) diff01++;
      for (int i = 0; i < 3; i++)
        if (valid3[i]) begin
          if (dest3[i*2 +: 2] == 2'd3) chk(1'b0, "R4 range n3", dest3[i*2 +: 2], 2);
          else hist3[dest3[i*2 +: 2]]++;
        end
    end
    for (int i = 0; i < 4; i++)
      chk(vcnt[i] > 880 && vcnt[i] < 1120, "R3 rate", vcnt[i], 1000);
    total = hist[0] + hist[1] + hist[2] + hist[3];
    for (int k = 0; k < 4; k++)
      chk(hist[k]*400 > total*85 && hist[k]*400 < total*115, "R4 uniform n4", hist[k], total/4);
    total3 = hist3[0] + hist3[1] + hist3[2];
    chk(total3 > 9000, "R4 n3 offered", total3, 12000);
    for (int k = 0; k < 3; k++)
      chk(hist3[k]*300 > total3*85 && hist3[k]*300 < total3*115, "R4 uniform n3", hist3[k], total3/3);
    chk(diff01 > 800, "R10 distinct streams", diff01, 1500);

    // R6: saturated, random ready
    prob = 16'h0; sat = 1'b1; ready = 4'h0;
    @(negedge clk);
    for (int c = 0; c < 500; c++) begin
      ready = 4'($urandom);
      @(negedge clk);
      if (valid != 4'hF) chk(1'b0, "R6 backlog", valid, 15);
    end
    chk(valid == 4'hF, "R6 backlog end", valid, 15);
    sat = 1'b0;

    // R7, R8, R9: meter
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(meter_on == 1'b1 && slot == 0, "R7 start", slot, 0);
    chk(dcnt == '0, "R7 clear", dcnt[31:0], 0);
    exp_slot = 0;
    foreach (exp_d[k]) exp_d[k] = 0;
    for (int c = 0; c < 37; c++) begin
      dlv = 4'($urandom);
      for (int j = 0; j < 4; j++) if (dlv[j]) exp_d[j]++;
      exp_slot++;
      @(negedge clk);
    end
    stop = 1'b1; dlv = 4'hF;
    @(negedge clk);
    stop = 1'b0;
    chk(meter_on == 1'b0, "R9 stop", meter_on, 0);
    chk(slot == 32'(exp_slot), "R8 slots", slot, exp_slot);
    for (int j = 0; j < 4; j++)
      chk(dcnt[j*32 +: 32] == 32'(exp_d[j]), "R8 deliveries", dcnt[j*32 +: 32], exp_d[j]);
    repeat (5) @(negedge clk);
    chk(slot == 32'(exp_slot), "R9 frozen slots", slot, exp_slot);
    for (int j = 0; j < 4; j++)
      chk(dcnt[j*32 +: 32] == 32'(exp_d[j]), "R9 frozen deliveries", dcnt[j*32 +: 32], exp_d[j]);
    start = 1'b1; stop = 1'b1; dlv = 4'h0;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk(meter_on == 1'b1 && slot == 0, "R7 start beats stop", slot, 0);
    @(negedge clk);
    chk(slot == 1, "R8 one per slot", slot, 1);

    // R11: two-port saturated switch with random arbitration
    for (int c = 0; c < 20000; c++) begin
      start2 = (c == 0);
      ready2 = 2'b00; dlv2 = 2'b00;
      for (int o = 0; o < 2; o++) begin
        logic [1:0] want;
        for (int i = 0; i < 2; i++) want[i] = valid2[i] && (dest2[i] == 1'(o));
        if (want == 2'b11) ready2[$urandom % 2] = 1'b1;
        else ready2 = ready2 | want;
        dlv2[o] = |want;
      end
      @(negedge clk);
    end
    start2 = 1'b0; stop2 = 1'b1; ready2 = 2'b00; dlv2 = 2'b00;
    @(negedge clk);
    stop2 = 1'b0;
    chk(slot2 == 32'd19999, "R11 slot count", slot2, 19999);
    for (int o = 0; o < 2; o++)
      chk(longint'(dcnt2[o*32 +: 32]) * 1000 > longint'(slot2) * 720 &&
          longint'(dcnt2[o*32 +: 32]) * 1000 < longint'(slot2) * 780,
          "R11 throughput", dcnt2[o*32 +: 32], 15000);

    summary();
    $finish;
  end
endmodule